// File: doc/BRIEF.md
# Self-Checking GF(2^8) Inverter Round

This block inverts sixteen bytes in parallel in GF(2^8), using the reduction polynomial x^8 + x^4 + x^3 + x + 1 (0x11B). It is the nonlinear core of one cipher round's substitution layer. It is purely combinational. Each of the sixteen lanes has its own error detector. The detector multiplies the lane's input by the lane's delivered output, but forms only the two lowest bits of that field product. It compares those two bits with the value the identity x·x⁻¹ = 1 predicts.

A mismatch raises that lane's error flag. The sixteen flags are ORed into one round-level error signal. Detection is data dependent: for a given fault, some inputs expose it and others do not. A persistent fault therefore becomes unlikely to stay hidden over many different inputs. A per-lane XOR mask sits on each inverter output, ahead of the check, so that a bench can inject corrupted results.

Top module: `gf_inv_round_chk`

## Requirements
- R1: With a zero fault mask, each lane's output byte is the multiplicative inverse of its input byte modulo 0x11B, for every nonzero input.
- R2: A lane whose input byte is 0x00 outputs 0x00 when its fault mask is zero.
- R3: With all fault masks zero, no lane error flag and no round error are raised, for any input.
- R4: Lane i uses bits 8i+7..8i of x_bus, fault_mask and y_bus. Its output byte equals the true inverse XOR that lane's fault mask byte.
- R5: lane_err[i] is 1 exactly when bits 1..0 of the field product x·y of lane i differ from the expected value. The expected value is 2'b01 for nonzero x and 2'b00 for x = 0.
- R6: A lane whose input byte is 0x00 never raises its error flag, whatever its fault mask.
- R7: round_err is 1 exactly when at least one lane error flag is 1.
- R8: A fault mask on one lane changes only that lane's output byte and error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_bus | input | 128 | Sixteen input bytes, lane i in bits 8i+7..8i |
| fault_mask | input | 128 | Per-lane XOR mask applied to each inverter result before checking |
| y_bus | output | 128 | Sixteen delivered (possibly corrupted) inverse bytes |
| lane_err | output | 16 | Per-lane error flags |
| round_err | output | 1 | OR of all lane error flags |

## Verification
The assertions assume that the inputs are settled when they are sampled. No assertion expects a fault to be caught: that outcome depends on the data, so only the implications that hold for every input are asserted. These cover clean lanes, zero inputs and unit inputs. The stimulus changes the inputs once per cycle, just after the rising edge. It sweeps all 256 input values with no faults, then drives zero and unit inputs under faults, single-lane faults, and random inputs with random masks. Every lane is compared against a brute-force reference on each cycle.

// File: rtl/gf_inv_round_chk.sv
module gf_inv_lane (
  input  logic [7:0] x,
  input  logic [7:0] fmask,
  output logic [7:0] y,
  output logic       err
);
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] sq, prod;
    sq   = a;
    prod = 8'h01;
    for (int k = 0; k < 7; k++) begin
      sq   = gmul(sq, sq);
      prod = gmul(prod, sq);
    end
    return prod;
  endfunction

  function automatic logic [7:0] xpow(input int d);
    logic [7:0] v;
    v = 8'h01;
    for (int k = 0; k < 14; k++)
      if (k < d) v = {v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00);
    return v;
  endfunction

  function automatic logic [1:0] low_prod(input logic [7:0] a, input logic [7:0] b);
    logic [1:0] s;
    logic [7:0] r;
    s = 2'b00;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        r = xpow(i + j);
        if (a[i] & b[j]) s = s ^ r[1:0];
      end
    return s;
  endfunction

  logic [1:0] expect_bits;

  assign y           = ginv(x) ^ fmask;
  assign expect_bits = (x != 8'h00) ? 2'b01 : 2'b00;
  assign err         = low_prod(x, y) != expect_bits;
endmodule

module gf_inv_round_chk #(
  parameter int LANES = 16
) (
  input  logic [8*LANES-1:0] x_bus,
  input  logic [8*LANES-1:0] fault_mask,
  output logic [8*LANES-1:0] y_bus,
  output logic [LANES-1:0]   lane_err,
  output logic               round_err
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    gf_inv_lane u_lane (
      .x     (x_bus[8*g +: 8]),
      .fmask (fault_mask[8*g +: 8]),
      .y     (y_bus[8*g +: 8]),
      .err   (lane_err[g])
    );
  end

  assign round_err = |lane_err;
endmodule

module gf_inv_round_chk_sva #(
  parameter int LANES = 16
) (
  input logic [8*LANES-1:0] x_bus,
  input logic [8*LANES-1:0] fault_mask,
  input logic [8*LANES-1:0] y_bus,
  input logic [LANES-1:0]   lane_err,
  input logic               round_err
);
  always_comb begin
    if (fault_mask == '0) assert_clean_round_R3: assert (!round_err);
    if (round_err) assert_round_has_lane_R7: assert ($countones(lane_err) > 0);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    always_comb begin
      if (fault_mask[8*g +: 8] == 8'h00)
        assert_clean_lane_R8: assert (!lane_err[g]);
      if (x_bus[8*g +: 8] == 8'h00)
        assert_zero_silent_R6: assert (!lane_err[g]);
      if (x_bus[8*g +: 8] == 8'h00 && fault_mask[8*g +: 8] == 8'h00)
        assert_zero_maps_zero_R2: assert (y_bus[8*g +: 8] == 8'h00);
      if (x_bus[8*g +: 8] == 8'h01 && fault_mask[8*g +: 8] == 8'h00)
        assert_one_maps_one_R1: assert (y_bus[8*g +: 8] == 8'h01);
    end
  end
endmodule

bind gf_inv_round_chk gf_inv_round_chk_sva #(.LANES(LANES)) u_sva (.*);

// File: tb/tb_gf_inv_round_chk.sv
module tb_gf_inv_round_chk;
  localparam int L = 16;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [8*L-1:0] x_bus, fault_mask, y_bus;
  logic [L-1:0]   lane_err;
  logic           round_err;

  gf_inv_round_chk #(.LANES(L)) dut (.*);

  int checks = 0, fails = 0;
  int inv_tab [256];

  function automatic int mulb(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) p ^= (a << i);
    end
    for (int d = 14; d >= 8; d--)
      if ((p >> d) & 1) p ^= (32'h11B << (d - 8));
    return p & 255;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int any = 0;
    for (int i = 0; i < L; i++) begin
      int xv = x_bus[8*i +: 8];
      int mv = fault_mask[8*i +: 8];
      int yv = inv_tab[xv] ^ mv;
      int ev = ((mulb(xv, yv) & 3) != ((xv != 0) ? 1 : 0)) ? 1 : 0;
      any |= ev;
      chk({tag, " R4 y"}, y_bus[8*i +: 8], yv);
      chk({tag, " R5 err"}, lane_err[i], ev);
    end
    chk({tag, " R7 round"}, round_err, any);
  endtask

  task automatic apply(logic [8*L-1:0] xv, logic [8*L-1:0] mv, string tag);
    @(posedge clk);
    #1;
    x_bus = xv;
    fault_mask = mv;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1500000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [8*L-1:0] xv, mv;
    inv_tab[0] = 0;
    for (int a = 1; a < 256; a++)
      for (int b = 1; b < 256; b++)
        if (mulb(a, b) == 1) inv_tab[a] = b;
    x_bus = '0;
    fault_mask = '0;
    #2;
    chk("R2 initial y zero", y_bus, 0);
    chk("R3 initial round", round_err, 0);

    // R1 R3: sweep all 256 values fault-free
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < L; i++) xv[8*i +: 8] = 8'(c * 16 + i);
      apply(xv, '0, "sweep R1");
      chk("R3 clean lanes", lane_err, 0);
    end
    // R2 R6: zero inputs with faults
    apply('0, {L{8'h5A}}, "zero R6");
    chk("R6 zero never flags", lane_err, 0);
    // x=1 with each single-bit fault
    for (int b = 0; b < 8; b++) apply({L{8'h01}}, {L{8'(1 << b)}}, "unit R5");
    // R8: single-lane fault
    for (int i = 0; i < L; i++) begin
      for (int k = 0; k < L; k++) xv[8*k +: 8] = 8'($urandom_range(1, 255));
      mv = '0;
      mv[8*i +: 8] = 8'h03;
      apply(xv, mv, "single R8");
      for (int k = 0; k < L; k++)
        if (k != i) begin
          chk("R8 other lane y", y_bus[8*k +: 8], inv_tab[xv[8*k +: 8]]);
          chk("R8 other lane err", lane_err[k], 0);
        end
    end
    // random
    for (int c = 0; c < 200; c++) begin
      for (int k = 0; k < L; k++) begin
        xv[8*k +: 8] = 8'($urandom_range(0, 255));
        mv[8*k +: 8] = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(1, 255)) : 8'h00;
      end
      apply(xv, mv, "random R5");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule